// File: doc/BRIEF.md
# PHY Power-Up Initialization Sequencer

This block brings a storage-interface PHY out of power-down without software help. Right after reset is released, or later on a start pulse while it is idle, it walks a fixed script over an 8-bit register port. Most steps read a pad or line-control register, OR in a set of enable bits and write the result back.

Early in the script it repeatedly reads a status register until the pad calibration flag comes up. If the flag does not appear within a time limit given in microseconds, it gives up. The script ends with a direct write that selects the PHY's basic-speed mode.

The register port uses a plain request/acknowledge handshake. An error reply from the port stops the script. The outcome is reported as a one-cycle done pulse on success, or a sticky error flag on failure.

Top module: `phy_init_seq`

## Requirements
- R1: When reset is released the sequence starts by itself, with no start pulse needed.
- R2: A start pulse while idle clears the error flag one cycle later and runs the whole script again from its first step.
- R3: A start pulse while the script is running is ignored. Exactly one full script's worth of transfers and a single done pulse result.
- R4: Each read-modify-write step reads a register (we=0) and then writes (we=1) to the same address the read data ORed with that step's mask. The steps run in this order:
  - 0x01 mask 0x42
  - 0x02 mask 0x02
  - (calibration poll)
  - 0x06 mask 0x03
  - 0x08 mask 0x02
  - 0x20 mask 0x01
  - 0x07 mask 0xFF
  - 0x09 mask 0xFF
  - 0x21 mask 0xFF
  - 0x22 mask 0x01
  - 0x23 mask 0x01
  - 0x0F mask 0x07
- R5: Between the 0x02 and 0x06 steps, register 0x03 is read repeatedly until bit 4 of the read data is 1. Other bits of that data are ignored.
- R6: If calibration is not seen, the error flag rises in the following window:
  - The window is measured from the first 0x03 request.
  - The limit is CLK_MHZ*TIMEOUT_US cycles.
  - The flag rises no earlier than that limit and no more than 4 cycles after it.
  - No further register access follows.
- R7: An acknowledge that carries err_i on any read or write sets the error flag and ends the script with no further request and no done pulse.
- R8: The last step writes 0x04 to register 0x11 without reading it first.
- R9: On success done_o is high for exactly one cycle and error_o stays low.
- R10: error_o, once set, holds until the next accepted start or reset.
- R11: While a request waits for acknowledge, address, write enable and write data stay stable.
- R12: During reset reg_req_o, done_o and error_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only while idle |
| reg_req_o | output | 1 | Register transfer request |
| reg_we_o | output | 1 | 1 = write, 0 = read |
| reg_addr_o | output | 8 | Register address |
| reg_wdata_o | output | 8 | Write data |
| reg_ack_i | input | 1 | Transfer complete, one cycle |
| reg_err_i | input | 1 | Transfer failed, valid with ack |
| reg_rdata_i | input | 8 | Read data, valid with ack |
| done_o | output | 1 | One-cycle success pulse |
| error_o | output | 1 | Sticky failure flag |

## Verification
A wrong step index or opcode appears on the register port within the next transfer: a wrong address, a write where a read belongs, or a write value that is not the read data with the mask ORed in. The bench compares the full transfer log against the script after every run.

A stuck or miscounting timeout counter shows up at the error flag. The flag then rises outside a four-cycle window around the limit, or the 0x06 step starts when it should not.

A corrupted state register shows up within a transfer or two as one of these:
- a repeated or missing transfer;
- a second done pulse;
- an error flag that drops without a start.

// File: rtl/phy_init_pkg.sv
package phy_init_pkg;
  typedef enum logic [1:0] {OP_RMW, OP_POLL, OP_WR} op_e;

  typedef struct packed {
    op_e        op;
    logic [7:0] addr;
    logic [7:0] bits;
  } step_t;

  localparam int N_STEPS = 13;
  localparam int STEP_W  = $clog2(N_STEPS);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_RD, S_WR, S_NEXT} state_e;
endpackage

// File: rtl/phy_init_script.sv
module phy_init_script
  import phy_init_pkg::*;
(
  input  logic [STEP_W-1:0] idx_i,
  output step_t             step_o,
  output logic              last_o
);
  always_comb begin
    unique case (idx_i)
      4'd0:    step_o = '{OP_RMW,  8'h01, 8'h42};
      4'd1:    step_o = '{OP_RMW,  8'h02, 8'h02};
      4'd2:    step_o = '{OP_POLL, 8'h03, 8'h10};
      4'd3:    step_o = '{OP_RMW,  8'h06, 8'h03};
      4'd4:    step_o = '{OP_RMW,  8'h08, 8'h02};
      4'd5:    step_o = '{OP_RMW,  8'h20, 8'h01};
      4'd6:    step_o = '{OP_RMW,  8'h07, 8'hFF};
      4'd7:    step_o = '{OP_RMW,  8'h09, 8'hFF};
      4'd8:    step_o = '{OP_RMW,  8'h21, 8'hFF};
      4'd9:    step_o = '{OP_RMW,  8'h22, 8'h01};
      4'd10:   step_o = '{OP_RMW,  8'h23, 8'h01};
      4'd11:   step_o = '{OP_RMW,  8'h0F, 8'h07};
      default: step_o = '{OP_WR,   8'h11, 8'h04};
    endcase
  end

  assign last_o = (idx_i == STEP_W'(N_STEPS - 1));
endmodule

// File: rtl/phy_init_timer.sv
module phy_init_timer #(
  parameter int LIMIT = 10000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (clr_i)                           cnt_q <= '0;
    else if (en_i && cnt_q != CW'(LIMIT))     cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == CW'(LIMIT));

  // R6: counter saturates at the limit
  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LIMIT));
  a_r6_clr_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !expired_o);
endmodule

// File: rtl/phy_init_seq.sv
module phy_init_seq
  import phy_init_pkg::*;
#(
  parameter int CLK_MHZ    = 100,
  parameter int TIMEOUT_US = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output logic       reg_req_o,
  output logic       reg_we_o,
  output logic [7:0] reg_addr_o,
  output logic [7:0] reg_wdata_o,
  input  logic       reg_ack_i,
  input  logic       reg_err_i,
  input  logic [7:0] reg_rdata_i,
  output logic       done_o,
  output logic       error_o
);
  localparam int LIMIT = CLK_MHZ * TIMEOUT_US;

  state_e            state_q;
  logic [STEP_W-1:0] step_q;
  logic [7:0]        data_q;
  logic              done_q, err_q;
  step_t             cur;
  logic              last, expired, poll_en;

  phy_init_script u_script (
    .idx_i  (step_q),
    .step_o (cur),
    .last_o (last)
  );

  assign poll_en = (state_q == S_RD) && (cur.op == OP_POLL);

  phy_init_timer #(.LIMIT(LIMIT)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (state_q == S_LOAD),
    .en_i      (poll_en),
    .expired_o (expired)
  );

  assign reg_req_o   = (state_q == S_RD) || (state_q == S_WR);
  assign reg_we_o    = (state_q == S_WR);
  assign reg_addr_o  = cur.addr;
  assign reg_wdata_o = data_q;
  assign done_o      = done_q;
  assign error_o     = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_LOAD;  // run on reset release
      step_q  <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          step_q  <= '0;
          err_q   <= 1'b0;
          state_q <= S_LOAD;
        end
        S_LOAD: begin
          if (cur.op == OP_WR) begin
            data_q  <= cur.bits;
            state_q <= S_WR;
          end else begin
            state_q <= S_RD;
          end
        end
        S_RD: if (reg_ack_i) begin
          if (reg_err_i) begin
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end else if (cur.op == OP_POLL) begin
            if ((reg_rdata_i & cur.bits) != 8'h00) begin
              state_q <= S_NEXT;
            end else if (expired) begin
              err_q   <= 1'b1;
              state_q <= S_IDLE;
            end
          end else begin
            data_q  <= reg_rdata_i | cur.bits;
            state_q <= S_WR;
          end
        end
        S_WR: if (reg_ack_i) begin
          if (reg_err_i) err_q <= 1'b1;
          state_q <= reg_err_i ? S_IDLE : S_NEXT;
        end
        S_NEXT: begin
          if (last) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            step_q  <= step_q + 1'b1;
            state_q <= S_LOAD;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R11: request fields held until acknowledge
  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && !reg_ack_i |=> reg_req_o && $stable(reg_addr_o)
                                && $stable(reg_we_o) && $stable(reg_wdata_o));
  // R9: done is a single-cycle pulse, never with error
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_done_no_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !error_o);
  // R10: error sticky without start
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o && !start_i |=> error_o);
  // R8: mode register only ever written with 0x04
  a_r8_mode_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && reg_addr_o == 8'h11 |-> reg_we_o && reg_wdata_o == 8'h04);
  // R7: error reply stops traffic
  a_r7_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && reg_ack_i && reg_err_i |=> !reg_req_o && error_o);
endmodule

// File: tb/phy_init_seq_tb.sv
module phy_init_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ = 2;
  localparam int TIMEOUT_US = 10;
  localparam int LIMIT = CLK_MHZ * TIMEOUT_US;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic req, we, ack = 1'b0, err = 1'b0, done, error;
  logic [7:0] addr, wdata, rdata = 8'h00;

  phy_init_seq #(.CLK_MHZ(CLK_MHZ), .TIMEOUT_US(TIMEOUT_US)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .reg_req_o(req), .reg_we_o(we), .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_ack_i(ack), .reg_err_i(err), .reg_rdata_i(rdata),
    .done_o(done), .error_o(error));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int cyc = 0;
  logic [7:0] mem [256];
  logic       log_we [128];
  logic [7:0] log_addr [128], log_data [128];
  int log_n = 0, stat_reads = 0, cal_need = 1;
  int resp_wait = 0, wait_cnt = 0, done_cnt = 0, hold_viol = 0;
  logic fail_en = 1'b0, fail_wr_only = 1'b0;
  logic [7:0] fail_addr = 8'h00;
  logic hold_valid = 1'b0, hold_we;
  logic [7:0] hold_addr, hold_wdata;
  int first_stat_cyc = -1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // register port model, driven away from the active edge
  always @(negedge clk) begin
    if (done) done_cnt++;
    if (hold_valid && req && (addr != hold_addr || we != hold_we || wdata != hold_wdata))
      hold_viol++;
    if (ack) begin
      ack = 1'b0; err = 1'b0;
    end else if (req && rst_n) begin
      if (wait_cnt < resp_wait) wait_cnt++;
      else begin
        wait_cnt = 0;
        ack = 1'b1;
        err = fail_en && addr == fail_addr && (!fail_wr_only || we);
        if (addr == 8'h03 && !we) begin
          if (first_stat_cyc < 0) first_stat_cyc = cyc;
          stat_reads++;
          rdata = (stat_reads >= cal_need) ? 8'hF0 : 8'hE0;
        end else begin
          rdata = mem[addr];
        end
        if (we && !err) mem[addr] = wdata;
        if (log_n < 128) begin
          log_we[log_n] = we; log_addr[log_n] = addr;
          log_data[log_n] = we ? wdata : rdata;
        end
        log_n++;
      end
    end
    hold_valid = req && !ack;
    hold_addr = addr; hold_we = we; hold_wdata = wdata;
  end

  function automatic logic [7:0] rmw_addr(int i);
    case (i)
      0: return 8'h01; 1: return 8'h02; 2: return 8'h06; 3: return 8'h08;
      4: return 8'h20; 5: return 8'h07; 6: return 8'h09; 7: return 8'h21;
      8: return 8'h22; 9: return 8'h23; default: return 8'h0F;
    endcase
  endfunction

  function automatic logic [7:0] rmw_mask(int i);
    case (i)
      0: return 8'h42; 1: return 8'h02; 2: return 8'h03; 3: return 8'h02;
      4: return 8'h01; 5: return 8'hFF; 6: return 8'hFF; 7: return 8'hFF;
      8: return 8'h01; 9: return 8'h01; default: return 8'h07;
    endcase
  endfunction

  // compare the transfer log with the full script (R4, R5, R8)
  task automatic verify_log(input int n_stat, input string tag);
    int bad = 0, k = 0;
    int total = 22 + n_stat + 1;
    chk(log_n == total, {tag, " R4 transfer count"}, log_n, total);
    if (log_n != total) return;
    for (int i = 0; i < 11; i++) begin
      if (i == 2)
        for (int s = 0; s < n_stat; s++) begin
          if (log_we[k] || log_addr[k] != 8'h03) bad++;
          k++;
        end
      if (log_we[k] || log_addr[k] != rmw_addr(i)) bad++;
      if (!log_we[k+1] || log_addr[k+1] != rmw_addr(i) ||
          log_data[k+1] != (log_data[k] | rmw_mask(i))) bad++;
      k += 2;
    end
    chk(bad == 0, {tag, " R4 R5 script order and RMW data"}, bad, 0);
    chk(log_we[k] && log_addr[k] == 8'h11 && log_data[k] == 8'h04 &&
        !(log_addr[k-1] == 8'h11), {tag, " R8 direct mode write"},
        {log_addr[k], log_data[k]}, 16'h1104);
  endtask

  task automatic clear_run(input int need);
    log_n = 0; stat_reads = 0; cal_need = need; first_stat_cyc = -1; done_cnt = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_flag(input bit on_err, input int max, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < max && !seen; i++) begin
      @(negedge clk);
      if (on_err ? error : (done_cnt > 0)) seen = 1'b1;
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 256; i++) mem[i] = 8'h80 ^ 8'(i);
    mem[8'h11] = 8'hAA;
    clear_run(1);
    repeat (3) @(negedge clk);
    chk(!req && !done && !error, "R12 outputs low in reset",
        {req, done, error}, 0);
  endtask

  task automatic t_auto();
    bit seen;
    @(negedge clk); rst_n = 1'b1;
    wait_flag(0, 500, seen);
    chk(seen, "R1 auto run after reset", seen, 1);
    repeat (3) @(negedge clk);
    chk(done_cnt == 1 && !error, "R9 single done, no error", done_cnt, 1);
    verify_log(1, "auto");
    chk(mem[8'h01] == 8'hC3 && mem[8'h0F] == 8'h8F && mem[8'h11] == 8'h04,
        "R4 R8 final register values", {mem[8'h01], mem[8'h0F]}, 16'hC38F);
  endtask

  task automatic t_multi_poll();
    bit seen;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    clear_run(4);
    pulse_start();
    wait_flag(0, 500, seen);
    chk(seen, "R2 start runs script", seen, 1);
    verify_log(4, "poll4");
    chk(mem[8'h07] == 8'hFF && mem[8'h06] == 8'h03, "R5 R4 after multi poll",
        mem[8'h06], 8'h03);
  endtask

  task automatic t_start_ignored();
    bit seen;
    clear_run(2);
    pulse_start();
    repeat (10) @(negedge clk);
    pulse_start();
    wait_flag(0, 500, seen);
    repeat (40) @(negedge clk);
    chk(done_cnt == 1, "R3 one done only", done_cnt, 1);
    verify_log(2, "R3");
  endtask

  task automatic t_access_err();
    bit seen;
    int n_at;
    clear_run(1);
    fail_en = 1'b1; fail_wr_only = 1'b0; fail_addr = 8'h20;
    pulse_start();
    wait_flag(1, 500, seen);
    chk(seen, "R7 error on read reply", seen, 1);
    n_at = log_n;
    chk(!log_we[n_at-1] && log_addr[n_at-1] == 8'h20, "R7 last transfer is failed read",
        log_addr[n_at-1], 8'h20);
    repeat (30) @(negedge clk);
    chk(log_n == n_at && done_cnt == 0, "R7 no traffic after error", log_n, n_at);
    chk(error, "R10 error held", error, 1);
    fail_en = 1'b0;
    clear_run(1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!error, "R2 start clears error", error, 0);
    wait_flag(0, 500, seen);
    chk(seen && !error, "R10 recovery run ok", seen, 1);
  endtask

  task automatic t_write_err();
    bit seen;
    clear_run(1);
    fail_en = 1'b1; fail_wr_only = 1'b1; fail_addr = 8'h11;
    pulse_start();
    wait_flag(1, 500, seen);
    repeat (5) @(negedge clk);
    chk(seen && done_cnt == 0 && log_we[log_n-1] && log_addr[log_n-1] == 8'h11,
        "R7 failed final write aborts", done_cnt, 0);
    fail_en = 1'b0;
  endtask

  task automatic t_timeout();
    bit seen;
    int dt, n06 = 0;
    clear_run(1000);
    pulse_start();
    wait_flag(1, 500, seen);
    dt = cyc - first_stat_cyc;
    chk(seen && dt >= LIMIT && dt <= LIMIT + 4, "R6 timeout window", dt, LIMIT);
    repeat (20) @(negedge clk);
    for (int i = 0; i < log_n && i < 128; i++) if (log_addr[i] == 8'h06) n06++;
    chk(n06 == 0 && !req, "R6 no access after timeout", n06, 0);
    chk(error, "R10 error held after timeout", error, 1);
  endtask

  task automatic t_slow_port();
    bit seen;
    clear_run(2);
    resp_wait = 3; hold_viol = 0;
    pulse_start();
    wait_flag(0, 2000, seen);
    chk(seen && hold_viol == 0, "R11 request held stable", hold_viol, 0);
    verify_log(2, "slow");
    resp_wait = 0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_auto();
        t_multi_poll();
        t_start_ignored();
        t_access_err();
        t_write_err();
        t_timeout();
        t_slow_port();
      end
      begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule